// File: doc/BRIEF.md
# Debug Event Status Register

This block holds a sticky record of processor debug events in one 32-bit register. Event detectors elsewhere send one-cycle pulses: instruction done, branch taken, interrupt taken, trap, each instruction address comparator, the read and write hits of each data address comparator, and an unconditional event. The register latches these pulses into dedicated bits, but only while the core is in a debug mode. Software reads the value through a plain read port. It clears bits by writing a mask, in which every 1 clears the matching bit.

The block also records that a hard reset has happened. It raises an imprecise-event flag when an event lands while debug interrupts cannot be taken. It raises a flag when the event came from a variable-length-encoded instruction. From the stored bits and three control levels it produces a level debug interrupt request: debug-enable, internal debug mode and external debug mode. The reset record and the variable-length flag are left out of that request.

Top module: `dbg_evt_status`

## Requirements
- R1: When `int_mode` or `ext_mode` is 1, each event pulse sets its own bit at the next edge. The bit positions are: unconditional 3, instruction done 4, branch 5, interrupt taken 6, trap 7, address compares 8 to 11 (`evt_iac[0]` at 8), data compare reads 12 to 13, and data compare writes 14 to 15 (comparator 0 at the lower bit).
- R2: A cycle with `wr_en`=1 clears, at the next edge, every bit whose `wr_mask` bit is 1. Bits whose mask bit is 0 keep their value.
- R3: When `int_mode` and `ext_mode` are both 0, event pulses change no bit of the register.
- R4: If an event set and a mask clear hit the same bit in the same cycle, the bit reads 1 afterwards.
- R5: After reset, `rd_data` reads 0x00000001 and `dbg_irq` is 0.
- R6: Bits [1:0] hold the reset record. 01 means a hard reset was seen, and 00 means it was cleared since. A `hrst_note` pulse writes 01 in any mode. Bit 1 always reads 0.
- R7: Bit 2, the imprecise flag, is set when an event sets its bit while `dbg_en`=0 and `ext_mode`=0.
- R8: The unconditional event pulse sets bit 3 and no other event bit.
- R9: Bit 16 is set when an event sets its bit while `evt_vle_tag` is 1.
- R10: `dbg_irq` is 1 exactly when `dbg_en`=1, `int_mode`=1, `ext_mode`=0 and a stored bit other than bits 0, 1 and 16 is 1. It follows the stored value and the current control levels with no added delay.
- R11: Bits 31 to 17 always read 0, and writes to them have no effect.
- R12: `rd_data` shows the stored value in the same cycle. A mask write changes it only after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_inst_done | input | 1 | Instruction done event pulse |
| evt_branch | input | 1 | Branch taken event pulse |
| evt_intr | input | 1 | Interrupt taken event pulse |
| evt_trap | input | 1 | Trap event pulse |
| evt_iac | input | N_IAC (4) | Instruction address compare pulses |
| evt_dac_rd | input | N_DAC (2) | Data address compare read pulses |
| evt_dac_wr | input | N_DAC (2) | Data address compare write pulses |
| evt_uncond | input | 1 | Unconditional event pulse |
| evt_vle_tag | input | 1 | Marks this cycle's events as variable-length-instruction events |
| hrst_note | input | 1 | Pulse: a hard reset was observed |
| dbg_en | input | 1 | Debug interrupt enable level |
| int_mode | input | 1 | Internal debug mode level |
| ext_mode | input | 1 | External debug mode level |
| wr_en | input | 1 | Software write strobe |
| wr_mask | input | REG_W (32) | Clear mask; 1 bits clear |
| rd_data | output | REG_W (32) | Current register value |
| dbg_irq | output | 1 | Debug interrupt request level |

## Verification
The bench drives a cycle where a trap pulse and a mask bit for the trap bit arrive together. A design that let the clear win would drop the event. It pulses every source with both debug modes off and expects an unchanged register; a design that ignored the mode gate would record stray events. It then leaves only the reset record or the variable-length flag set and expects the interrupt request to stay low. It also steps each control level to check that the request follows them with no added delay. A long random run compares every cycle against a behavioural model, both just before and just after each edge. That catches a write taking effect early, and an imprecise flag raised in external mode.

// File: rtl/dbg_evt_pkg.sv
package dbg_evt_pkg;

  // Reset record encodings (bits [1:0]); codes 1x are never produced.
  typedef enum logic [1:0] {
    RREC_NONE = 2'b00,
    RREC_HARD = 2'b01
  } rrec_e;

  // Fixed low field positions.
  localparam int RREC_LSB = 0;
  localparam int IMP_BIT  = 2;
  localparam int UNC_BIT  = 3;
  localparam int DONE_BIT = 4;
  localparam int BR_BIT   = 5;
  localparam int INTR_BIT = 6;
  localparam int TRAP_BIT = 7;
  localparam int IAC_LSB  = 8;

  // Positions that depend on comparator counts.
  function automatic int dacr_lsb(input int n_iac);
    return IAC_LSB + n_iac;
  endfunction

  function automatic int dacw_lsb(input int n_iac, input int n_dac);
    return dacr_lsb(n_iac) + n_dac;
  endfunction

  function automatic int vle_pos(input int n_iac, input int n_dac);
    return dacw_lsb(n_iac, n_dac) + n_dac;
  endfunction

endpackage

// File: rtl/dbg_evt_gather.sv
module dbg_evt_gather
  import dbg_evt_pkg::*;
#(
  parameter int REG_W = 32,
  parameter int N_IAC = 4,
  parameter int N_DAC = 2
) (
  input  logic             evt_inst_done,
  input  logic             evt_branch,
  input  logic             evt_intr,
  input  logic             evt_trap,
  input  logic [N_IAC-1:0] evt_iac,
  input  logic [N_DAC-1:0] evt_dac_rd,
  input  logic [N_DAC-1:0] evt_dac_wr,
  input  logic             evt_uncond,
  input  logic             evt_vle_tag,
  input  logic             hrst_note,
  input  logic             dbg_en,
  input  logic             int_mode,
  input  logic             ext_mode,
  output logic [REG_W-1:0] set_vec
);

  localparam int DACR_LSB = dacr_lsb(N_IAC);
  localparam int DACW_LSB = dacw_lsb(N_IAC, N_DAC);
  localparam int VLE_BIT  = vle_pos(N_IAC, N_DAC);

  logic [REG_W-1:0] raw;
  logic             mode_ok;
  logic             hit;

  // Place each event pulse at its own status position.
  always_comb begin
    raw           = '0;
    raw[UNC_BIT]  = evt_uncond;
    raw[DONE_BIT] = evt_inst_done;
    raw[BR_BIT]   = evt_branch;
    raw[INTR_BIT] = evt_intr;
    raw[TRAP_BIT] = evt_trap;
    for (int i = 0; i < N_IAC; i++) begin
      raw[IAC_LSB + i] = evt_iac[i];
    end
    for (int j = 0; j < N_DAC; j++) begin
      raw[DACR_LSB + j] = evt_dac_rd[j];
      raw[DACW_LSB + j] = evt_dac_wr[j];
    end
  end

  assign mode_ok = int_mode | ext_mode;
  assign hit     = mode_ok & (|raw);

  // Qualified event bits plus the derived flags and reset record.
  always_comb begin
    set_vec           = hit ? raw : '0;
    set_vec[IMP_BIT]  = hit & ~dbg_en & ~ext_mode;
    set_vec[VLE_BIT]  = hit & evt_vle_tag;
    set_vec[RREC_LSB] = hrst_note;
  end

endmodule

// File: rtl/dbg_stat_store.sv
module dbg_stat_store #(
  parameter int               REG_W     = 32,
  parameter logic [REG_W-1:0] LIVE_MASK = '1,
  parameter logic [REG_W-1:0] RST_VAL   = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [REG_W-1:0] set_vec,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_mask,
  output logic [REG_W-1:0] stat_q
);

  logic [REG_W-1:0] clr_vec;
  logic [REG_W-1:0] stat_d;

  assign clr_vec = wr_en ? wr_mask : '0;
  // Clear first, then OR the sets so a same-cycle event survives.
  assign stat_d  = ((stat_q & ~clr_vec) | set_vec) & LIVE_MASK;

  always_ff @(posedge clk) begin
    if (rst) stat_q <= RST_VAL & LIVE_MASK;
    else     stat_q <= stat_d;
  end

endmodule

// File: rtl/dbg_irq_qual.sv
module dbg_irq_qual #(
  parameter int               REG_W     = 32,
  parameter logic [REG_W-1:0] EXCL_MASK = '0
) (
  input  logic [REG_W-1:0] stat_q,
  input  logic             dbg_en,
  input  logic             int_mode,
  input  logic             ext_mode,
  output logic             irq
);

  logic counted;
  logic allowed;

  assign counted = |(stat_q & ~EXCL_MASK);
  assign allowed = dbg_en & int_mode & ~ext_mode;
  assign irq     = allowed & counted;

endmodule

// File: rtl/dbg_evt_status.sv
module dbg_evt_status
  import dbg_evt_pkg::*;
#(
  parameter int REG_W = 32,
  parameter int N_IAC = 4,
  parameter int N_DAC = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             evt_inst_done,
  input  logic             evt_branch,
  input  logic             evt_intr,
  input  logic             evt_trap,
  input  logic [N_IAC-1:0] evt_iac,
  input  logic [N_DAC-1:0] evt_dac_rd,
  input  logic [N_DAC-1:0] evt_dac_wr,
  input  logic             evt_uncond,
  input  logic             evt_vle_tag,
  input  logic             hrst_note,
  input  logic             dbg_en,
  input  logic             int_mode,
  input  logic             ext_mode,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_mask,
  output logic [REG_W-1:0] rd_data,
  output logic             dbg_irq
);

  localparam int VLE_BIT = vle_pos(N_IAC, N_DAC);
  localparam int USED_W  = VLE_BIT + 1;

  // Stored bits: all used positions except the never-produced high
  // bit of the reset record.
  localparam logic [REG_W-1:0] USED_MASK = {{(REG_W-USED_W){1'b0}}, {USED_W{1'b1}}};
  localparam logic [REG_W-1:0] LIVE_MASK = USED_MASK & ~(REG_W'(1) << (RREC_LSB + 1));
  localparam logic [REG_W-1:0] RST_VAL   = REG_W'(RREC_HARD) << RREC_LSB;
  localparam logic [REG_W-1:0] EXCL_MASK = (REG_W'(3) << RREC_LSB) | (REG_W'(1) << VLE_BIT);

  logic [REG_W-1:0] set_vec;
  logic [REG_W-1:0] stat_q;

  dbg_evt_gather #(
    .REG_W(REG_W), .N_IAC(N_IAC), .N_DAC(N_DAC)
  ) u_gather (
    .evt_inst_done(evt_inst_done),
    .evt_branch   (evt_branch),
    .evt_intr     (evt_intr),
    .evt_trap     (evt_trap),
    .evt_iac      (evt_iac),
    .evt_dac_rd   (evt_dac_rd),
    .evt_dac_wr   (evt_dac_wr),
    .evt_uncond   (evt_uncond),
    .evt_vle_tag  (evt_vle_tag),
    .hrst_note    (hrst_note),
    .dbg_en       (dbg_en),
    .int_mode     (int_mode),
    .ext_mode     (ext_mode),
    .set_vec      (set_vec)
  );

  dbg_stat_store #(
    .REG_W(REG_W), .LIVE_MASK(LIVE_MASK), .RST_VAL(RST_VAL)
  ) u_store (
    .clk    (clk),
    .rst    (rst),
    .set_vec(set_vec),
    .wr_en  (wr_en),
    .wr_mask(wr_mask),
    .stat_q (stat_q)
  );

  dbg_irq_qual #(
    .REG_W(REG_W), .EXCL_MASK(EXCL_MASK)
  ) u_irq (
    .stat_q  (stat_q),
    .dbg_en  (dbg_en),
    .int_mode(int_mode),
    .ext_mode(ext_mode),
    .irq     (dbg_irq)
  );

  assign rd_data = stat_q;

endmodule

// File: rtl/dbg_evt_status_chk.sv
module dbg_evt_status_chk
  import dbg_evt_pkg::*;
#(
  parameter int REG_W = 32,
  parameter int N_IAC = 4,
  parameter int N_DAC = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             evt_trap,
  input logic             evt_vle_tag,
  input logic             hrst_note,
  input logic             dbg_en,
  input logic             int_mode,
  input logic             ext_mode,
  input logic             wr_en,
  input logic [REG_W-1:0] wr_mask,
  input logic [REG_W-1:0] rd_data,
  input logic             dbg_irq
);

  localparam int VLE_BIT = vle_pos(N_IAC, N_DAC);
  localparam int USED_W  = VLE_BIT + 1;

  // R2: with nothing able to set, masked bits read 0 after the edge
  p_mask_clear_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !int_mode && !ext_mode && !hrst_note)
    |=> ((rd_data & $past(wr_mask)) == '0));

  // R2: without a write no bit ever falls
  p_sticky_r2: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ((rd_data & $past(rd_data)) == $past(rd_data)));

  p_modes_off_r3: assert property (@(posedge clk) disable iff (rst)
    (!int_mode && !ext_mode && !hrst_note && !wr_en) |=> $stable(rd_data));

  p_set_wins_r4: assert property (@(posedge clk) disable iff (rst)
    (int_mode && evt_trap && wr_en && wr_mask[TRAP_BIT]) |=> rd_data[TRAP_BIT]);

  p_hrst_record_r6: assert property (@(posedge clk) disable iff (rst)
    hrst_note |=> (rd_data[RREC_LSB +: 2] == RREC_HARD));

  p_rrec_high_zero_r6: assert property (@(posedge clk) disable iff (rst)
    rd_data[RREC_LSB + 1] == 1'b0);

  p_imprecise_r7: assert property (@(posedge clk) disable iff (rst)
    (evt_trap && int_mode && !dbg_en && !ext_mode) |=> rd_data[IMP_BIT]);

  p_vle_flag_r9: assert property (@(posedge clk) disable iff (rst)
    (evt_trap && int_mode && evt_vle_tag) |=> rd_data[VLE_BIT]);

  p_irq_blocked_r10: assert property (@(posedge clk) disable iff (rst)
    (!dbg_en || !int_mode || ext_mode) |-> !dbg_irq);

  p_irq_raised_r10: assert property (@(posedge clk) disable iff (rst)
    (dbg_en && int_mode && !ext_mode && rd_data[TRAP_BIT]) |-> dbg_irq);

  p_reserved_zero_r11: assert property (@(posedge clk) disable iff (rst)
    rd_data[REG_W-1:USED_W] == '0);

endmodule

bind dbg_evt_status dbg_evt_status_chk #(
  .REG_W(REG_W), .N_IAC(N_IAC), .N_DAC(N_DAC)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .evt_trap   (evt_trap),
  .evt_vle_tag(evt_vle_tag),
  .hrst_note  (hrst_note),
  .dbg_en     (dbg_en),
  .int_mode   (int_mode),
  .ext_mode   (ext_mode),
  .wr_en      (wr_en),
  .wr_mask    (wr_mask),
  .rd_data    (rd_data),
  .dbg_irq    (dbg_irq)
);

// File: tb/dbg_evt_status_bench.sv
`timescale 1ns/1ps
module dbg_evt_status_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        evt_inst_done = 0, evt_branch = 0, evt_intr = 0, evt_trap = 0;
  logic [3:0]  evt_iac = '0;
  logic [1:0]  evt_dac_rd = '0, evt_dac_wr = '0;
  logic        evt_uncond = 0, evt_vle_tag = 0, hrst_note = 0;
  logic        dbg_en = 0, int_mode = 0, ext_mode = 0;
  logic        wr_en = 0;
  logic [31:0] wr_mask = '0;
  logic [31:0] rd_data;
  logic        dbg_irq;

  int          vectors = 0;
  int          miscmp  = 0;
  bit          finished = 0;
  string       tag = "R5";
  logic [31:0] exp_q = 32'h1;

  always #5 clk = ~clk;

  dbg_evt_status u_dbg_evt_status (
    .clk(clk), .rst(rst),
    .evt_inst_done(evt_inst_done), .evt_branch(evt_branch),
    .evt_intr(evt_intr), .evt_trap(evt_trap), .evt_iac(evt_iac),
    .evt_dac_rd(evt_dac_rd), .evt_dac_wr(evt_dac_wr),
    .evt_uncond(evt_uncond), .evt_vle_tag(evt_vle_tag),
    .hrst_note(hrst_note), .dbg_en(dbg_en), .int_mode(int_mode),
    .ext_mode(ext_mode), .wr_en(wr_en), .wr_mask(wr_mask),
    .rd_data(rd_data), .dbg_irq(dbg_irq)
  );

  // Event bit positions taken from R1.
  function automatic logic [31:0] event_bits();
    logic [31:0] e = '0;
    e[3] = evt_uncond;
    e[4] = evt_inst_done;
    e[5] = evt_branch;
    e[6] = evt_intr;
    e[7] = evt_trap;
    for (int i = 0; i < 4; i++) e[8 + i] = evt_iac[i];
    for (int j = 0; j < 2; j++) begin
      e[12 + j] = evt_dac_rd[j];
      e[14 + j] = evt_dac_wr[j];
    end
    return e;
  endfunction

  function automatic logic [31:0] model_next(input logic [31:0] cur);
    logic [31:0] n = cur;
    logic [31:0] e = event_bits();
    if (wr_en) n = n & ~wr_mask;
    if ((int_mode || ext_mode) && e != 0) begin
      n = n | e;
      if (!dbg_en && !ext_mode) n[2] = 1'b1;
      if (evt_vle_tag) n[16] = 1'b1;
    end
    if (hrst_note) n[0] = 1'b1;
    return n & 32'h0001_FFFD;
  endfunction

  function automatic logic model_irq(input logic [31:0] cur);
    return dbg_en && int_mode && !ext_mode && ((cur & 32'h0000_FFFC) != 0);
  endfunction

  task automatic cmp();
    logic ei = model_irq(exp_q);
    vectors++;
    if (rd_data !== exp_q || dbg_irq !== ei) begin
      miscmp++;
      $display("FAIL %s: rd_data=%h irq=%b expected rd_data=%h irq=%b",
               tag, rd_data, dbg_irq, exp_q, ei);
    end
  endtask

  task automatic idle();
    evt_inst_done = 0; evt_branch = 0; evt_intr = 0; evt_trap = 0;
    evt_iac = '0; evt_dac_rd = '0; evt_dac_wr = '0;
    evt_uncond = 0; evt_vle_tag = 0; hrst_note = 0;
    wr_en = 0; wr_mask = '0;
  endtask

  // Inputs are driven right after a falling edge; compare before the
  // rising edge (R12: write not yet visible) and after it.
  task automatic tick();
    logic [31:0] nx;
    #1 cmp();
    nx = model_next(exp_q);
    @(posedge clk);
    exp_q = nx;
    @(negedge clk);
    cmp();
    idle();
  endtask

  task automatic clear_all();
    wr_en = 1; wr_mask = 32'hFFFF_FFFF;
    tick();
  endtask

  task automatic modes(input logic de, input logic im, input logic em);
    dbg_en = de; int_mode = im; ext_mode = em;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      miscmp++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    tag = "R5"; exp_q = 32'h1; cmp();

    // R12: clear the reset record; before the edge the value is unchanged
    tag = "R12"; wr_en = 1; wr_mask = 32'h3; tick();

    // R1: each source alone, debug interrupts on, internal mode
    tag = "R1"; modes(1, 1, 0);
    evt_inst_done = 1; tick(); clear_all();
    evt_branch = 1;    tick(); clear_all();
    evt_intr = 1;      tick(); clear_all();
    evt_trap = 1;      tick(); clear_all();
    for (int i = 0; i < 4; i++) begin
      evt_iac[i] = 1'b1; tick(); clear_all();
    end
    for (int j = 0; j < 2; j++) begin
      evt_dac_rd[j] = 1'b1; tick(); clear_all();
      evt_dac_wr[j] = 1'b1; tick(); clear_all();
    end
    // R1 in external mode alone
    modes(0, 0, 1); evt_branch = 1; tick(); clear_all();

    // R8: unconditional event
    tag = "R8"; modes(1, 1, 0); evt_uncond = 1; tick(); clear_all();

    // R10: request follows controls and the stored bits
    tag = "R10"; evt_trap = 1; tick();
    modes(1, 1, 1); tick();
    modes(0, 1, 0); tick();
    modes(1, 0, 0); tick();
    modes(1, 1, 0); tick();
    wr_en = 1; wr_mask = 32'h80; tick();

    // R3: every source pulsed with both modes off
    tag = "R3"; modes(1, 0, 0);
    evt_trap = 1; evt_iac = 4'hF; evt_dac_rd = 2'h3; evt_dac_wr = 2'h3;
    evt_uncond = 1; evt_inst_done = 1; evt_branch = 1; evt_intr = 1;
    evt_vle_tag = 1; tick(); tick();

    // R4: set and clear of the same bit together
    tag = "R4"; modes(1, 1, 0);
    evt_iac[2] = 1; wr_en = 1; wr_mask = 32'hFFFF_FFFF; tick();
    clear_all();

    // R6: reset record in any mode; alone it raises no request
    tag = "R6"; modes(1, 1, 0); hrst_note = 1; tick(); tick();
    modes(0, 0, 0); wr_en = 1; wr_mask = 32'h1; tick();
    hrst_note = 1; tick();
    modes(1, 1, 0); hrst_note = 1; wr_en = 1; wr_mask = 32'h3; tick();
    clear_all();

    // R7: imprecise flag with interrupts disabled, not in external mode
    tag = "R7"; modes(0, 1, 0); evt_intr = 1; tick();
    modes(1, 1, 0); tick(); clear_all();
    modes(0, 1, 1); evt_intr = 1; tick(); clear_all();

    // R9: variable-length flag alone does not raise the request
    tag = "R9"; modes(1, 1, 0); evt_branch = 1; evt_vle_tag = 1; tick();
    wr_en = 1; wr_mask = 32'h20; tick(); tick();
    clear_all();

    // R2: partial mask clears only selected bits
    tag = "R2"; modes(1, 1, 0);
    evt_iac = 4'hF; evt_dac_wr = 2'h3; tick();
    wr_en = 1; wr_mask = 32'h0000_4500; tick();
    wr_en = 1; wr_mask = 32'h0; tick();
    clear_all();

    // R11: reserved positions stay 0 whatever is written
    tag = "R11"; wr_en = 1; wr_mask = 32'hFFFE_0000; tick();
    evt_trap = 1; wr_en = 1; wr_mask = 32'hAAAA_0000; tick();
    clear_all();

    // Random run against the model
    tag = "R12";
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] r = $urandom;
      evt_inst_done = (r[3:0] == 0);
      evt_branch    = (r[7:4] == 1);
      evt_intr      = (r[11:8] == 2);
      evt_trap      = (r[15:12] == 3);
      evt_iac       = $urandom & $urandom & $urandom;
      evt_dac_rd    = $urandom & $urandom & $urandom;
      evt_dac_wr    = $urandom & $urandom & $urandom;
      evt_uncond    = (r[19:16] == 4);
      evt_vle_tag   = r[20];
      hrst_note     = (r[27:21] == 0);
      if (r[31:28] == 0) modes(r[21], r[22], r[23] & r[24]);
      wr_en         = (r[26:24] == 0);
      wr_mask       = $urandom;
      tick();
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    $finish;
  end

endmodule